// File: doc/BRIEF.md
# General-Purpose Up-Counting Timer with Compare and Event Output

This block is a 32-bit up-counter with a small register interface. Software loads a start value, picks one-shot or auto-reload operation and an optional power-of-two prescaler, then sets the run bit. The counter steps once per prescaled tick. When it steps past all-ones it raises an overflow flag. In one-shot mode it then stops by itself. In auto-reload mode it restarts from the reload value.

A compare register raises a match flag when the count reaches it. A capture register latches the count on a selected edge of an input pin. All three flags are sticky and are cleared by writing one to them. Two independent masks combine the flags into an interrupt line and a wake line.

An event output pin idles at a programmable level. It can produce a one-cycle pulse or a toggle on overflow, or on either overflow or match.

Top module: `gp_timer`

## Requirements
- R1: After reset every register reads zero and irq_o, wake_o and evt_o are low. The byte offsets are: control 0x00, status 0x04, interrupt mask 0x08, wake mask 0x0C, count 0x10, reload 0x14, restart 0x18, compare 0x1C, capture 0x20.
- R2: While control bit 0 (run) is set with the prescaler off, the count rises by one every clock, starting on the edge after the write that sets run. While run is clear the count holds.
- R3: With control bit 1 (reload) clear, the step from 0xFFFFFFFF wraps the count to 0, clears run and sets status bit 1 (overflow).
- R4: With reload set, the step from 0xFFFFFFFF loads the count from the reload register, sets status bit 1, and counting continues.
- R5: A write of any value to the restart offset copies the reload register into the count. A write to the count offset sets the count directly.
- R6: With control bit 2 set, the count steps once every 2^(ratio+1) clocks, where ratio is control bits 5:3. The prescaler restarts from zero whenever run is clear.
- R7: With control bit 6 (compare enable) set, a step that brings the count equal to the compare register sets status bit 0.
- R8: Status flags stay set, including after the timer stops, until a write to the status offset with a one in that bit position. Writing zero to a bit leaves it unchanged.
- R9: irq_o is high when any status bit is set whose bit is also set in the interrupt mask. wake_o does the same with the wake mask.
- R10: evt_o equals control bit 7 (idle level) XOR an event phase. Control bits 9:8 select the event source: 00 none, 01 overflow, 10 overflow or match. Control bit 10 selects toggle (1) or one-cycle pulse (0). Source 00 clears the phase one clock later.
- R11: Control bits 12:11 select the capture edge on cap_i: 00 off, 01 rising, 10 falling, 11 both. A selected edge latches the count into the capture register and sets status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| cap_i | input | 1 | Capture input, synchronous to clk_i |
| irq_o | output | 1 | Masked interrupt request |
| wake_o | output | 1 | Masked wake request |
| evt_o | output | 1 | Compare/overflow event output |

## Verification
A counter that steps at the wrong rate or from the wrong value shows on the next count read. An overflow therefore appears either too early or too late, by exactly the number of misplaced ticks. A lost run-clear in one-shot mode leaves control bit 0 set and the count moving past zero, which is visible on the first read after the wrap. A flag that is set, cleared or masked wrongly shows on irq_o or wake_o in the same cycle. A wrong event phase inverts evt_o from the cycle after the event until the next event or the next write with source 00.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // control word, bit 0 is the least significant field
  typedef struct packed {
    logic [1:0] cap_edge;   // 12:11  bit0 rising, bit1 falling
    logic       toggle;     // 10
    logic [1:0] out_trig;   // 9:8
    logic       out_def;    // 7
    logic       cmp_en;     // 6
    logic [2:0] pre_ratio;  // 5:3
    logic       pre_en;     // 2
    logic       reload;     // 1
    logic       run;        // 0
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

  localparam logic [1:0] TRIG_NONE = 2'b00;
  localparam logic [1:0] TRIG_OVF  = 2'b01;
  localparam logic [1:0] TRIG_ANY  = 2'b10;

  localparam int unsigned FLAG_N   = 3;
  localparam int unsigned ST_MATCH = 0;
  localparam int unsigned ST_OVF   = 1;
  localparam int unsigned ST_CAP   = 2;

  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_STAT  = 'h04;
  localparam int unsigned OFS_IEN   = 'h08;
  localparam int unsigned OFS_WEN   = 'h0C;
  localparam int unsigned OFS_CNT   = 'h10;
  localparam int unsigned OFS_LOAD  = 'h14;
  localparam int unsigned OFS_TRIG  = 'h18;
  localparam int unsigned OFS_MATCH = 'h1C;
  localparam int unsigned OFS_CAPT  = 'h20;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               pre_en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               tick_o
);

  localparam int DIV_W = 2 ** RATIO_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] term;
  logic             at_term;

  always_comb begin
    // terminal value 2^(ratio+1)-1: bits 0..ratio set
    for (int b = 0; b < DIV_W; b++) begin
      term[b] = (b <= int'(ratio_i));
    end
    at_term = (div_q == term);
    tick_o  = run_i & (~pre_en_i | at_term);
    if (!run_i || !pre_en_i || at_term) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic             trig_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             reload_i,
  input  logic             cmp_en_i,
  input  logic [CNT_W-1:0] match_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             match_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] stepped;
  logic             at_max;
  logic             busy;

  always_comb begin
    at_max  = &cnt_q;
    busy    = cnt_wr_i | trig_wr_i;
    if (at_max) begin
      stepped = reload_i ? load_i : '0;
    end else begin
      stepped = cnt_q + 1'b1;
    end
    if (cnt_wr_i) begin
      cnt_d = wdata_i;
    end else if (trig_wr_i) begin
      cnt_d = load_i;
    end else if (tick_i) begin
      cnt_d = stepped;
    end else begin
      cnt_d = cnt_q;
    end
    ovf_o   = tick_i & ~busy & at_max;
    match_o = tick_i & ~busy & cmp_en_i & (stepped == match_i);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/tmr_outgen.sv
module tmr_outgen
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n,
  input  logic [1:0] trig_i,
  input  logic       toggle_i,
  input  logic       def_i,
  input  logic       ovf_i,
  input  logic       match_i,
  output logic       out_o
);

  logic phase_q;
  logic phase_d;
  logic evt;

  always_comb begin
    evt = ((trig_i == TRIG_OVF) & ovf_i) |
          ((trig_i == TRIG_ANY) & (ovf_i | match_i));
    if (trig_i == TRIG_NONE) begin
      phase_d = 1'b0;
    end else if (toggle_i) begin
      phase_d = phase_q ^ evt;
    end else begin
      phase_d = evt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign out_o = def_i ^ phase_q;

endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8,
  parameter int RATIO_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic              cap_i,
  output logic              irq_o,
  output logic              wake_o,
  output logic              evt_o
);

  // reset: asserted at once, released after two edges
  logic rst_meta;
  logic rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  tmr_ctrl_t          ctrl_q, ctrl_d;
  logic [FLAG_N-1:0]  stat_q, stat_d, ien_q, ien_d, wen_q, wen_d;
  logic [FLAG_N-1:0]  stat_set, stat_clr;
  logic [CNT_W-1:0]   load_q, load_d, match_q, match_d, capt_q, capt_d;
  logic               cap_prev_q;
  logic               wr_ctrl, wr_stat, wr_ien, wr_wen, wr_cnt, wr_load, wr_trig, wr_match;
  logic               tick, ovf_evt, match_evt, cap_evt;
  logic [CNT_W-1:0]   count;

  always_comb begin
    wr_ctrl  = bus_wr_i & (bus_addr_i == ADDR_W'(OFS_CTRL));
    wr_stat  = bus_wr_i & (bus_addr_i == ADDR_W'(OFS_STAT));
    wr_ien   = bus_wr_i & (bus_addr_i == ADDR_W'(OFS_IEN));
    wr_wen   = bus_wr_i & (bus_addr_i == ADDR_W'(OFS_WEN));
    wr_cnt   = bus_wr_i & (bus_addr_i == ADDR_W'(OFS_CNT));
    wr_load  = bus_wr_i & (bus_addr_i == ADDR_W'(OFS_LOAD));
    wr_trig  = bus_wr_i & (bus_addr_i == ADDR_W'(OFS_TRIG));
    wr_match = bus_wr_i & (bus_addr_i == ADDR_W'(OFS_MATCH));
  end

  tmr_prescale #(.RATIO_W(RATIO_W)) u_pre (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .run_i    (ctrl_q.run),
    .pre_en_i (ctrl_q.pre_en),
    .ratio_i  (RATIO_W'(ctrl_q.pre_ratio)),
    .tick_o   (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .cnt_wr_i  (wr_cnt),
    .trig_wr_i (wr_trig),
    .wdata_i   (bus_wdata_i),
    .load_i    (load_q),
    .reload_i  (ctrl_q.reload),
    .cmp_en_i  (ctrl_q.cmp_en),
    .match_i   (match_q),
    .count_o   (count),
    .ovf_o     (ovf_evt),
    .match_o   (match_evt)
  );

  tmr_outgen u_out (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .trig_i   (ctrl_q.out_trig),
    .toggle_i (ctrl_q.toggle),
    .def_i    (ctrl_q.out_def),
    .ovf_i    (ovf_evt),
    .match_i  (match_evt),
    .out_o    (evt_o)
  );

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = tmr_ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
    end else if (ovf_evt && !ctrl_q.reload) begin
      ctrl_d.run = 1'b0;
    end

    cap_evt = (ctrl_q.cap_edge[0] & cap_i & ~cap_prev_q) |
              (ctrl_q.cap_edge[1] & ~cap_i & cap_prev_q);

    stat_set           = '0;
    stat_set[ST_MATCH] = match_evt;
    stat_set[ST_OVF]   = ovf_evt;
    stat_set[ST_CAP]   = cap_evt;
    stat_clr           = wr_stat ? bus_wdata_i[FLAG_N-1:0] : '0;
    stat_d             = (stat_q & ~stat_clr) | stat_set;

    ien_d   = wr_ien   ? bus_wdata_i[FLAG_N-1:0] : ien_q;
    wen_d   = wr_wen   ? bus_wdata_i[FLAG_N-1:0] : wen_q;
    load_d  = wr_load  ? bus_wdata_i : load_q;
    match_d = wr_match ? bus_wdata_i : match_q;
    capt_d  = cap_evt  ? count : capt_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      stat_q     <= '0;
      ien_q      <= '0;
      wen_q      <= '0;
      load_q     <= '0;
      match_q    <= '0;
      capt_q     <= '0;
      cap_prev_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      stat_q     <= stat_d;
      ien_q      <= ien_d;
      wen_q      <= wen_d;
      load_q     <= load_d;
      match_q    <= match_d;
      capt_q     <= capt_d;
      cap_prev_q <= cap_i;
    end
  end

  assign irq_o  = |(stat_q & ien_q);
  assign wake_o = |(stat_q & wen_q);

  always_comb begin
    case (bus_addr_i)
      ADDR_W'(OFS_CTRL):  bus_rdata_o = CNT_W'(ctrl_q);
      ADDR_W'(OFS_STAT):  bus_rdata_o = CNT_W'(stat_q);
      ADDR_W'(OFS_IEN):   bus_rdata_o = CNT_W'(ien_q);
      ADDR_W'(OFS_WEN):   bus_rdata_o = CNT_W'(wen_q);
      ADDR_W'(OFS_CNT):   bus_rdata_o = count;
      ADDR_W'(OFS_LOAD):  bus_rdata_o = load_q;
      ADDR_W'(OFS_MATCH): bus_rdata_o = match_q;
      ADDR_W'(OFS_CAPT):  bus_rdata_o = capt_q;
      default:            bus_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_n,
  input tmr_ctrl_t         ctrl,
  input logic              ovf_evt,
  input logic              wr_ctrl,
  input logic              wr_cnt,
  input logic              wr_trig,
  input logic              wr_stat,
  input logic [CNT_W-1:0]  wdata,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  load,
  input logic [FLAG_N-1:0] stat,
  input logic              evt_o
);

  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ctrl.run && !wr_cnt && !wr_trig) |=> $stable(count)); // R2

  AST_ONESHOT_HALT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ovf_evt && !ctrl.reload && !wr_ctrl) |=> !ctrl.run); // R3

  AST_RELOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ovf_evt && ctrl.reload) |=> (count == $past(load))); // R4

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stat[ST_OVF] && !(wr_stat && wdata[ST_OVF])) |=> stat[ST_OVF]); // R8

  AST_OUT_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ctrl.out_trig == TRIG_NONE) |=> (ctrl.out_trig != TRIG_NONE || evt_o == ctrl.out_def)); // R10

  AST_CAPTURE_OFF: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ctrl.cap_edge == 2'b00 && !stat[ST_CAP]) |=> !stat[ST_CAP]); // R11

endmodule

bind gp_timer gp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n),
  .ctrl    (ctrl_q),
  .ovf_evt (ovf_evt),
  .wr_ctrl (wr_ctrl),
  .wr_cnt  (wr_cnt),
  .wr_trig (wr_trig),
  .wr_stat (wr_stat),
  .wdata   (bus_wdata_i),
  .count   (count),
  .load    (load_q),
  .stat    (stat_q),
  .evt_o   (evt_o)
);

// File: tb/gp_timer_tb.sv
`timescale 1ns/1ps
module gp_timer_tb;

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_WT = 3'd2, OP_PIN = 3'd3;
  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_IEN = 8'h08, A_WEN = 8'h0C,
                         A_CNT = 8'h10, A_LOAD = 8'h14, A_TRIG = 8'h18, A_MATCH = 8'h1C,
                         A_CAPT = 8'h20;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;   // write data, expected value, or cycle count
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk(logic [2:0] op, logic [7:0] addr, logic [31:0] data, logic [3:0] req);
    mk = '{op: op, addr: addr, data: data, req: req};
  endfunction

  localparam int NV = 56;
  localparam vec_t TBL [0:NV-1] = '{
    mk(OP_RD,  A_CTRL, 32'h0, 4'd1),          // R1 reset state
    mk(OP_RD,  A_STAT, 32'h0, 4'd1),
    mk(OP_RD,  A_CNT,  32'h0, 4'd1),
    mk(OP_PIN, 8'h0,   32'h0, 4'd1),
    mk(OP_WR,  A_LOAD, 32'hFFFF_FFF0, 4'd5),  // R5 restart copies reload
    mk(OP_WR,  A_TRIG, 32'h1234, 4'd5),
    mk(OP_RD,  A_CNT,  32'hFFFF_FFF0, 4'd5),
    mk(OP_WR,  A_IEN,  32'h2, 4'd3),          // R3 one-shot
    mk(OP_WR,  A_CTRL, 32'h1, 4'd3),
    mk(OP_WT,  8'h0,   32'd20, 4'd3),
    mk(OP_RD,  A_CNT,  32'h0, 4'd3),
    mk(OP_RD,  A_CTRL, 32'h0, 4'd3),
    mk(OP_RD,  A_STAT, 32'h2, 4'd3),
    mk(OP_PIN, 8'h0,   32'h4, 4'd9),          // R9 overflow unmasked
    mk(OP_WR,  A_STAT, 32'h1, 4'd8),          // R8 write-one-to-clear
    mk(OP_RD,  A_STAT, 32'h2, 4'd8),
    mk(OP_WR,  A_STAT, 32'h2, 4'd8),
    mk(OP_RD,  A_STAT, 32'h0, 4'd8),
    mk(OP_PIN, 8'h0,   32'h0, 4'd9),
    mk(OP_WR,  A_LOAD, 32'hFFFF_FFFC, 4'd4),  // R4 auto-reload
    mk(OP_WR,  A_TRIG, 32'h0, 4'd4),
    mk(OP_WR,  A_CTRL, 32'h3, 4'd4),
    mk(OP_WT,  8'h0,   32'd4, 4'd4),
    mk(OP_RD,  A_CNT,  32'hFFFF_FFFC, 4'd4),
    mk(OP_RD,  A_STAT, 32'h2, 4'd4),
    mk(OP_WT,  8'h0,   32'd2, 4'd4),
    mk(OP_RD,  A_CNT,  32'hFFFF_FFFE, 4'd4),
    mk(OP_RD,  A_CTRL, 32'h3, 4'd4),
    mk(OP_WR,  A_CTRL, 32'h0, 4'd2),          // R2 stop
    mk(OP_RD,  A_CNT,  32'hFFFF_FFFF, 4'd2),
    mk(OP_WT,  8'h0,   32'd3, 4'd2),
    mk(OP_RD,  A_CNT,  32'hFFFF_FFFF, 4'd2),
    mk(OP_WR,  A_STAT, 32'h7, 4'd8),
    mk(OP_WR,  A_CNT,  32'h100, 4'd7),        // R7 compare
    mk(OP_WR,  A_MATCH,32'h105, 4'd7),
    mk(OP_WR,  A_IEN,  32'h1, 4'd7),
    mk(OP_WR,  A_CTRL, 32'h41, 4'd7),
    mk(OP_WT,  8'h0,   32'd3, 4'd7),
    mk(OP_RD,  A_CNT,  32'h103, 4'd2),
    mk(OP_RD,  A_STAT, 32'h0, 4'd7),
    mk(OP_WT,  8'h0,   32'd2, 4'd7),
    mk(OP_RD,  A_STAT, 32'h1, 4'd7),
    mk(OP_PIN, 8'h0,   32'h4, 4'd9),
    mk(OP_WR,  A_CTRL, 32'h0, 4'd7),
    mk(OP_WR,  A_STAT, 32'h7, 4'd8),
    mk(OP_WR,  A_CNT,  32'h0, 4'd6),          // R6 divide by 4
    mk(OP_WR,  A_CTRL, 32'h0D, 4'd6),
    mk(OP_WT,  8'h0,   32'd10, 4'd6),
    mk(OP_RD,  A_CNT,  32'h2, 4'd6),
    mk(OP_WR,  A_CTRL, 32'h0, 4'd6),
    mk(OP_RD,  A_CNT,  32'h2, 4'd6),
    mk(OP_WR,  A_CNT,  32'h0, 4'd6),          // R6 divide by 2
    mk(OP_WR,  A_CTRL, 32'h05, 4'd6),
    mk(OP_WT,  8'h0,   32'd6, 4'd6),
    mk(OP_WR,  A_CTRL, 32'h0, 4'd6),
    mk(OP_RD,  A_CNT,  32'h3, 4'd6)
  };

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        cap;
  logic        irq, wake, evt;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  gp_timer u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .cap_i       (cap),
    .irq_o       (irq),
    .wake_o      (wake),
    .evt_o       (evt)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, e);
  endtask

  task automatic pins(logic [2:0] e, string tag);
    #1;
    chk(tag, 32'({irq, wake, evt}), 32'(e));
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; cap = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(4);

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        OP_WR:   wr(TBL[i].addr, TBL[i].data);
        OP_RD:   rd(TBL[i].addr, TBL[i].data, $sformatf("R%0d vec %0d", TBL[i].req, i));
        OP_WT:   cyc(int'(TBL[i].data));
        default: pins(TBL[i].data[2:0], $sformatf("R%0d vec %0d", TBL[i].req, i));
      endcase
    end

    // R10 pulse on overflow, idle level 0, reload period 6
    wr(A_CNT, 32'hFFFF_FFFE);
    wr(A_LOAD, 32'hFFFF_FFFA);
    wr(A_CTRL, 32'h103);
    cyc(2);
    pins(3'b001, "R10 pulse high");
    cyc(1);
    pins(3'b000, "R10 pulse one cycle");
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h7);

    // R10 toggle on overflow-or-match, idle level 1
    wr(A_CNT, 32'h10);
    wr(A_MATCH, 32'h12);
    wr(A_CTRL, 32'h6C1);
    pins(3'b001, "R10 idle level");
    cyc(2);
    pins(3'b100, "R10 toggled on match");
    cyc(3);
    pins(3'b100, "R10 toggle holds");
    wr(A_CTRL, 32'h6C0);
    pins(3'b100, "R10 phase kept on stop");
    wr(A_CTRL, 32'h0);
    cyc(1);
    pins(3'b100, "R10 source none clears phase");
    wr(A_STAT, 32'h7);
    pins(3'b000, "R9 cleared");

    // R11 rising edge, R9 wake mask
    wr(A_IEN, 32'h0);
    wr(A_WEN, 32'h4);
    wr(A_CNT, 32'h55);
    wr(A_CTRL, 32'h800);
    cap = 1'b1;
    cyc(1);
    pins(3'b010, "R9 wake on capture");
    rd(A_CAPT, 32'h55, "R11 rising capture");
    rd(A_STAT, 32'h4, "R11 rising flag");
    wr(A_STAT, 32'h4);
    cap = 1'b0;
    cyc(2);
    rd(A_STAT, 32'h0, "R11 falling ignored in rising mode");

    // R11 falling edge
    wr(A_CNT, 32'h77);
    wr(A_CTRL, 32'h1000);
    cap = 1'b1;
    cyc(2);
    rd(A_STAT, 32'h0, "R11 rising ignored in falling mode");
    cap = 1'b0;
    cyc(1);
    rd(A_CAPT, 32'h77, "R11 falling capture");
    rd(A_STAT, 32'h4, "R11 falling flag");
    wr(A_STAT, 32'h4);

    // R11 both edges
    wr(A_CNT, 32'h99);
    wr(A_CTRL, 32'h1800);
    cap = 1'b1;
    cyc(1);
    rd(A_STAT, 32'h4, "R11 both rising");
    wr(A_STAT, 32'h4);
    cap = 1'b0;
    cyc(1);
    rd(A_STAT, 32'h4, "R11 both falling");
    rd(A_CAPT, 32'h99, "R11 both value");

    // R1 reset while running
    wr(A_CNT, 32'h5);
    wr(A_IEN, 32'h7);
    wr(A_CTRL, 32'h81);
    cyc(3);
    rst_ni = 1'b0;
    cyc(2);
    rd(A_CTRL, 32'h0, "R1 ctrl after reset");
    rd(A_CNT, 32'h0, "R1 count after reset");
    rd(A_STAT, 32'h0, "R1 status after reset");
    rd(A_CAPT, 32'h0, "R1 capture after reset");
    rd(A_IEN, 32'h0, "R1 mask after reset");
    pins(3'b000, "R1 pins after reset");
    rst_ni = 1'b1;
    cyc(4);
    rd(A_CNT, 32'h0, "R1 count held after release");

    summary();
    $finish;
  end

endmodule